// File: doc/BRIEF.md
# Interrupt Acknowledge and Arbitration Unit

This unit carries out the acknowledge step of interrupt service for a set of requesting modules. It works out the highest level among the pending requests and latches that level as the new CPU mask. It then places a special-space acknowledge address on its output. The address is a 20-bit all-ones prefix, followed by the 3-bit serviced level, followed by a trailing 1.

Every responder slot keeps its own pending request level, a 4-bit arbitration number and an 8-bit vector number. While an acknowledge is running, each slot compares the latched level with its own request level. Slots at that level contend one bit per cycle, most significant bit first, on a shared wired-OR line. A slot leaves the contention when it drives 0 but reads 1 on the line. The survivor presents its vector for one cycle. If no slot survives, the unit returns a fixed spurious vector instead.

Top module: `irq_ack_arbiter`

## Requirements
- R1: After reset, no slot is pending, `ack_busy`, `ack_done` and `ack_spurious` are 0, and `ack_level` is 0.
- R2: `ack_addr` always equals {20'hFFFFF, ack_level, 1'b1}, with the level in bits 3:1 and bit 0 set.
- R3: An `ack_start` sampled while idle, with at least one slot pending, latches the highest pending level into `ack_level` and raises `ack_busy` in the next cycle.
- R4: A request raised with level 0 never becomes pending. An `ack_start` sampled while no slot is pending has no effect: `ack_busy` stays 0.
- R5: Only slots whose pending level equals `ack_level` take part in contention. A pending slot at a lower level keeps its request, whatever its arbitration number.
- R6: Among the contending slots, the one with the largest arbitration number wins. `ack_done` is high for exactly one cycle, ARB_W+1 cycles after the start edge, and in that cycle `ack_vector` carries the winner's vector.
- R7: The winner's pending flag clears at the edge that ends the done cycle. Losing slots stay pending.
- R8: A slot whose arbitration number is 0 never wins. If no slot survives contention, the done cycle shows `ack_spurious`=1 and `ack_vector`=SPUR_VEC (default 8'h18), and all pending flags are kept.
- R9: If a winning slot raises a new request during its own done cycle, the new request is kept and the slot stays pending.
- R10: An `ack_start` that arrives while an acknowledge is already running is ignored: the running cycle ends on schedule, and no second acknowledge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_start | input | 1 | CPU asks for an acknowledge cycle |
| req_set | input | N_RESP | Per-slot request strobe |
| req_level | input | N_RESP*3 | Per-slot request level, captured on the strobe |
| arb_num | input | N_RESP*4 | Per-slot arbitration number |
| vec_num | input | N_RESP*8 | Per-slot vector number |
| req_pending | output | N_RESP | Per-slot pending flag |
| ack_busy | output | 1 | Acknowledge in progress |
| ack_level | output | 3 | Latched serviced level (CPU mask) |
| ack_addr | output | 24 | Special-space acknowledge address |
| ack_done | output | 1 | One-cycle completion strobe |
| ack_vector | output | 8 | Winner vector, or the spurious code |
| ack_spurious | output | 1 | No slot survived contention |

## Verification
Two events can fall in the same cycle: a slot's clear-on-win in the done cycle, and a fresh request strobe from that same slot. The bench raises the strobe in exactly the done cycle and then requires the slot to remain pending and to win a second acknowledge. It also overlaps a second `ack_start` with a running contention. That case is judged by the done strobe arriving at its normal cycle and by `ack_busy` dropping straight afterwards.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ARB  = 2'd1,
      SQ_DONE = 2'd2
   } seq_state_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irq_level_max.sv
module irq_level_max #(
   parameter int N_RESP = 4,
   parameter int LVL_W  = 3
) (
   input  logic [N_RESP*LVL_W-1:0] levels,
   output logic [LVL_W-1:0]        max_level
);
   always_comb begin
      max_level = '0;
      for (int i = 0; i < N_RESP; i++) begin
         if (levels[i*LVL_W +: LVL_W] > max_level)
            max_level = levels[i*LVL_W +: LVL_W];
      end
   end
endmodule

// File: rtl/irq_resp_slot.sv
module irq_resp_slot #(
   parameter int LVL_W = 3,
   parameter int ARB_W = 4,
   parameter int BW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_set,
   input  logic [LVL_W-1:0] req_level,
   input  logic [ARB_W-1:0] arb_num,
   input  logic             seq_start,
   input  logic [LVL_W-1:0] start_level,
   input  logic             seq_step,
   input  logic             seq_done,
   input  logic [BW-1:0]    bit_idx,
   input  logic             line,
   output logic             pending,
   output logic [LVL_W-1:0] eff_level,
   output logic             drive,
   output logic             alive
);
   logic             pend_q;
   logic [LVL_W-1:0] lvl_q;
   logic             alive_q;
   logic             won;

   assign won = seq_done & alive_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         lvl_q   <= '0;
         alive_q <= 1'b0;
      end else begin
         if (req_set && (req_level != '0)) begin
            pend_q <= 1'b1;
            lvl_q  <= req_level;
         end else if (won) begin
            pend_q <= 1'b0;
         end

         if (seq_start)
            alive_q <= pend_q && (lvl_q == start_level) && (arb_num != '0);
         else if (seq_step && alive_q && !arb_num[bit_idx] && line)
            alive_q <= 1'b0;
         else if (seq_done)
            alive_q <= 1'b0;
      end
   end

   assign pending   = pend_q;
   assign eff_level = pend_q ? lvl_q : '0;
   assign drive     = alive_q & arb_num[bit_idx];
   assign alive     = alive_q;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_ack_pkg::*;
#(
   parameter int LVL_W = 3,
   parameter int ARB_W = 4,
   parameter int BW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_start,
   input  logic [LVL_W-1:0] max_level,
   output logic             seq_start,
   output logic             seq_step,
   output logic             seq_done,
   output logic [BW-1:0]    bit_idx,
   output logic             busy,
   output logic [LVL_W-1:0] level_q
);
   seq_state_e state;
   logic [BW-1:0] cnt;

   assign seq_start = ack_start && (state == SQ_IDLE) && (max_level != '0);
   assign seq_step  = (state == SQ_ARB);
   assign seq_done  = (state == SQ_DONE);
   assign busy      = (state != SQ_IDLE);
   assign bit_idx   = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         cnt     <= '0;
         level_q <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (seq_start) begin
               state   <= SQ_ARB;
               cnt     <= BW'(ARB_W - 1);
               level_q <= max_level;
            end
            SQ_ARB: begin
               if (cnt == '0) state <= SQ_DONE;
               else           cnt   <= cnt - 1'b1;
            end
            SQ_DONE: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_ack_arbiter.sv
module irq_ack_arbiter
   import irq_ack_pkg::*;
#(
   parameter int          N_RESP   = 4,
   parameter int          LVL_W    = 3,
   parameter int          ARB_W    = 4,
   parameter int          VEC_W    = 8,
   parameter int          PREFIX_W = 20,
   parameter logic [7:0]  SPUR_VEC = 8'h18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ack_start,
   input  logic [N_RESP-1:0]          req_set,
   input  logic [N_RESP*LVL_W-1:0]    req_level,
   input  logic [N_RESP*ARB_W-1:0]    arb_num,
   input  logic [N_RESP*VEC_W-1:0]    vec_num,
   output logic [N_RESP-1:0]          req_pending,
   output logic                       ack_busy,
   output logic [LVL_W-1:0]           ack_level,
   output logic [PREFIX_W+LVL_W:0]    ack_addr,
   output logic                       ack_done,
   output logic [VEC_W-1:0]           ack_vector,
   output logic                       ack_spurious
);
   localparam int BW = idx_width(ARB_W);

   if (N_RESP < 1)  begin : g_bad_n   $error("N_RESP must be at least 1"); end
   if (ARB_W < 2)   begin : g_bad_arb $error("ARB_W must be at least 2"); end
   if (VEC_W < 8)   begin : g_bad_vec $error("VEC_W must hold the spurious code"); end
   if (LVL_W < 1)   begin : g_bad_lvl $error("LVL_W must be at least 1"); end

   logic [N_RESP*LVL_W-1:0] eff_levels;
   logic [N_RESP-1:0]       drive;
   logic [N_RESP-1:0]       alive;
   logic [LVL_W-1:0]        max_level;
   logic                    seq_start, seq_step, seq_done;
   logic [BW-1:0]           bit_idx;
   logic                    line;
   logic [VEC_W-1:0]        win_vec;

   irq_level_max #(.N_RESP(N_RESP), .LVL_W(LVL_W)) u_max (
      .levels    (eff_levels),
      .max_level (max_level)
   );

   irq_ack_seq #(.LVL_W(LVL_W), .ARB_W(ARB_W), .BW(BW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_start (ack_start),
      .max_level (max_level),
      .seq_start (seq_start),
      .seq_step  (seq_step),
      .seq_done  (seq_done),
      .bit_idx   (bit_idx),
      .busy      (ack_busy),
      .level_q   (ack_level)
   );

   for (genvar i = 0; i < N_RESP; i++) begin : g_slot
      irq_resp_slot #(.LVL_W(LVL_W), .ARB_W(ARB_W), .BW(BW)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .req_set     (req_set[i]),
         .req_level   (req_level[i*LVL_W +: LVL_W]),
         .arb_num     (arb_num[i*ARB_W +: ARB_W]),
         .seq_start   (seq_start),
         .start_level (max_level),
         .seq_step    (seq_step),
         .seq_done    (seq_done),
         .bit_idx     (bit_idx),
         .line        (line),
         .pending     (req_pending[i]),
         .eff_level   (eff_levels[i*LVL_W +: LVL_W]),
         .drive       (drive[i]),
         .alive       (alive[i])
      );
   end

   assign line = |drive;

   always_comb begin
      win_vec = '0;
      for (int i = 0; i < N_RESP; i++)
         if (alive[i]) win_vec = win_vec | vec_num[i*VEC_W +: VEC_W];
   end

   assign ack_done     = seq_done;
   assign ack_spurious = seq_done && (alive == '0);
   assign ack_vector   = !seq_done ? '0 : ((alive == '0) ? VEC_W'(SPUR_VEC) : win_vec);
   assign ack_addr     = {{PREFIX_W{1'b1}}, ack_level, 1'b1};
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk #(
   parameter int N_RESP = 4,
   parameter int LVL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_start,
   input logic              ack_busy,
   input logic              ack_done,
   input logic              ack_spurious,
   input logic [LVL_W-1:0]  ack_level,
   input logic [N_RESP-1:0] req_pending,
   input logic [N_RESP-1:0] alive
);
   a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_start && !ack_busy && (req_pending != '0)) |=> ack_busy);

   a_r4_no_pending_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_busy && (req_pending == '0)) |=> !ack_busy);

   a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_start && !ack_busy) |=> $stable(ack_level));

   a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |=> !ack_done);

   a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |-> ($countones(alive) <= 1));

   a_r8_spurious_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      ack_spurious |-> ack_done);

   a_r10_run_to_done: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_busy && !ack_done) |=> ack_busy);

   a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |=> !ack_busy);
endmodule

bind irq_ack_arbiter irq_ack_chk #(.N_RESP(N_RESP), .LVL_W(LVL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ack_start    (ack_start),
   .ack_busy     (ack_busy),
   .ack_done     (ack_done),
   .ack_spurious (ack_spurious),
   .ack_level    (ack_level),
   .req_pending  (req_pending),
   .alive        (alive)
);

// File: tb/irq_ack_arbiter_tb.sv
module irq_ack_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 4;
   localparam int ARB_W = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ack_start = 1'b0;
   logic [N-1:0]   req_set = '0;
   logic [N*3-1:0] req_level = '0;
   logic [N*4-1:0] arb_num = '0;
   logic [N*8-1:0] vec_num = '0;
   logic [N-1:0]   req_pending;
   logic           ack_busy;
   logic [2:0]     ack_level;
   logic [23:0]    ack_addr;
   logic           ack_done;
   logic [7:0]     ack_vector;
   logic           ack_spurious;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ack_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .req_set(req_set),
      .req_level(req_level), .arb_num(arb_num), .vec_num(vec_num),
      .req_pending(req_pending), .ack_busy(ack_busy), .ack_level(ack_level),
      .ack_addr(ack_addr), .ack_done(ack_done), .ack_vector(ack_vector),
      .ack_spurious(ack_spurious)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ack_start = 1'b0; req_set = '0;
      req_level = '0; arb_num = '0; vec_num = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic set_slot(input int i, input logic [2:0] lv, input logic [3:0] id, input logic [7:0] v);
      req_level[i*3 +: 3] = lv;
      arb_num[i*4 +: 4]   = id;
      vec_num[i*8 +: 8]   = v;
   endtask

   task automatic raise(input logic [N-1:0] m);
      @(negedge clk);
      req_set = m;
      @(posedge clk);
      @(negedge clk);
      req_set = '0;
   endtask

   // Drives one acknowledge and checks level, address, done timing, vector.
   task automatic run_ack(input string req, input logic [2:0] lv, input logic [7:0] v,
                          input logic spur, input logic mid_start, input logic [N-1:0] done_set);
      @(negedge clk);
      ack_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack_start = 1'b0;
      chk("R3", {req, " busy"}, 32'(ack_busy), 32'd1);
      chk("R3", {req, " level"}, 32'(ack_level), 32'(lv));
      chk("R2", {req, " addr"}, 32'(ack_addr), 32'({20'hFFFFF, lv, 1'b1}));
      chk("R6", {req, " no early done"}, 32'(ack_done), 32'd0);
      if (mid_start) begin
         ack_start = 1'b1;
         @(posedge clk);
         @(negedge clk);
         ack_start = 1'b0;
         repeat (ARB_W - 1) @(posedge clk);
      end else begin
         repeat (ARB_W) @(posedge clk);
      end
      @(negedge clk);
      chk("R6", {req, " done"}, 32'(ack_done), 32'd1);
      chk("R6", {req, " vector"}, 32'(ack_vector), 32'(v));
      chk("R8", {req, " spurious"}, 32'(ack_spurious), 32'(spur));
      req_set = done_set;
      @(posedge clk);
      @(negedge clk);
      req_set = '0;
      chk("R6", {req, " done one cycle"}, 32'(ack_done), 32'd0);
      chk("R10", {req, " idle after"}, 32'(ack_busy), 32'd0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "pending", 32'(req_pending), 32'd0);
      chk("R1", "busy", 32'(ack_busy), 32'd0);
      chk("R1", "done", 32'(ack_done), 32'd0);
      chk("R1", "spurious", 32'(ack_spurious), 32'd0);
      chk("R1", "level", 32'(ack_level), 32'd0);
      chk("R2", "reset addr", 32'(ack_addr), 32'h00FFFFF1);
   endtask

   task automatic t_no_pending();
      do_reset();
      set_slot(0, 3'd0, 4'd7, 8'h11);
      raise(4'b0001);
      chk("R4", "level0 not pending", 32'(req_pending), 32'd0);
      @(negedge clk);
      ack_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack_start = 1'b0;
      chk("R4", "start ignored busy", 32'(ack_busy), 32'd0);
      repeat (ARB_W + 1) @(posedge clk);
      @(negedge clk);
      chk("R4", "start ignored done", 32'(ack_done), 32'd0);
   endtask

   task automatic t_tiebreak();
      do_reset();
      set_slot(0, 3'd5, 4'd3,  8'hA0);
      set_slot(1, 3'd5, 4'd9,  8'hA1);
      set_slot(2, 3'd5, 4'd6,  8'hA2);
      set_slot(3, 3'd2, 4'd15, 8'hA3);
      raise(4'b1111);
      run_ack("tie1", 3'd5, 8'hA1, 1'b0, 1'b0, '0);
      chk("R7", "tie1 pending", 32'(req_pending), 32'b1101);
      run_ack("tie2", 3'd5, 8'hA2, 1'b0, 1'b0, '0);
      chk("R7", "tie2 pending", 32'(req_pending), 32'b1001);
      run_ack("tie3", 3'd5, 8'hA0, 1'b0, 1'b0, '0);
      chk("R5", "low level kept", 32'(req_pending), 32'b1000);
      run_ack("low", 3'd2, 8'hA3, 1'b0, 1'b0, '0);
      chk("R7", "all served", 32'(req_pending), 32'd0);
   endtask

   task automatic t_zero_id();
      do_reset();
      set_slot(0, 3'd4, 4'd0, 8'h55);
      set_slot(1, 3'd1, 4'd8, 8'h66);
      raise(4'b0011);
      run_ack("zero", 3'd4, 8'h18, 1'b1, 1'b0, '0);
      chk("R8", "pending kept", 32'(req_pending), 32'b0011);
   endtask

   task automatic t_same_cycle();
      do_reset();
      set_slot(1, 3'd3, 4'd5, 8'h33);
      raise(4'b0010);
      run_ack("rearm", 3'd3, 8'h33, 1'b0, 1'b0, 4'b0010);
      chk("R9", "rearm kept", 32'(req_pending), 32'b0010);
      run_ack("rearm2", 3'd3, 8'h33, 1'b0, 1'b0, '0);
      chk("R9", "rearm served", 32'(req_pending), 32'd0);
   endtask

   task automatic t_mid_start();
      do_reset();
      set_slot(0, 3'd6, 4'd2, 8'h70);
      set_slot(2, 3'd6, 4'd12, 8'h72);
      raise(4'b0101);
      run_ack("mid", 3'd6, 8'h72, 1'b0, 1'b1, '0);
      chk("R10", "loser left", 32'(req_pending), 32'b0001);
   endtask

   initial begin
      t_reset();
      t_no_pending();
      t_tiebreak();
      t_zero_id();
      t_same_cycle();
      t_mid_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule